// File: doc/BRIEF.md
# Low-Speed Preamble Transmit Sequencer

This block sits in the digital transmit path of a USB transceiver. It takes packet bytes from the link and drives the bus line state: J, K or SE0, together with an output-enable. It runs from a clock at four times the full-speed bit rate. One full-speed bit lasts 4 clocks and one low-speed bit lasts 32 clocks.

When the 2-bit transceiver-select input holds 11b at the moment a packet begins, the packet is sent in preamble form:
- A 16-bit header (SYNC then the PRE packet identifier) goes out at full-speed rate.
- The line is held at J, then released so that the pull-up keeps J through the rest of a four-bit-time gap.
- The packet goes out at low-speed rate: a generated SYNC, the link's bytes with bit stuffing and NRZI, and an end-of-packet.

For any other select value the same payload framing is sent at full-speed rate with no header and no gap. Edge rates are always the full-speed ones, and the block says so on a constant output.

The link hands bytes over with a valid/ready handshake, and a last flag marks the final byte. The block keeps one byte waiting behind the shift register. It asks for the next byte as soon as the waiting byte moves into the shifter. A link that falls behind ends the packet early: the block sends the end-of-packet sequence when it finds no byte waiting.

Top module: `ls_pre_tx`

## Requirements
- R1: After reset, line_out is J (01), line_oe is 0 and tx_ready is 1. The line codes are J=01, K=10 and SE0=00.
- R2: The mode is taken from xcvr_sel in the cycle the first byte is accepted.
  - 11b selects preamble form.
  - Any other value sends the payload at 4 clocks per bit, starting the cycle after acceptance, with no header.
- R3: In preamble form, the cycle after the first byte is accepted starts 16 header bits of 4 clocks each, with line_oe high. The bits are the SYNC byte 0x80 then 0x3C, each least significant bit first. They are NRZI coded from J: a 0 toggles J/K and a 1 holds.
- R4: Right after the last header bit, the line is J with line_oe high for 4 clocks.
- R5: After that hold, line_oe is low (line J) for 12 clocks, so 16 clocks pass between the header's end and the low-speed SYNC.
- R6: The payload is a generated SYNC byte 0x80 followed by the link's bytes, each least significant bit first. It is NRZI coded starting from J, at 32 clocks per bit in preamble form.
- R7: After six consecutive payload ones, a zero bit is inserted. This also applies after the final byte, before end-of-packet.
- R8: After the payload, SE0 is driven for two bit times, then J for one bit time. line_oe then falls and the block is idle.
- R9: tx_ready is high when idle and low whenever a byte is already waiting. It therefore stays low through the header of a multi-byte packet. It stays low after the last byte is accepted until the packet ends.
- R10: A change of xcvr_sel during a packet does not alter that packet. It applies to the next packet.
- R11: fs_edge is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the full-speed bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| xcvr_sel | input | 2 | Transceiver select; 11b chooses preamble form |
| tx_data | input | 8 | Packet byte from the link |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_last | input | 1 | The offered byte is the final one of the packet |
| tx_ready | output | 1 | Block accepts the offered byte this cycle |
| line_out | output | 2 | Bus line state: 01 J, 10 K, 00 SE0 |
| line_oe | output | 1 | Bus driver enable |
| fs_edge | output | 1 | Full-speed edge-rate select, always 1 |

## Verification
A wrong slot counter shows up at once as a J/K edge one or more clocks off the expected grid. A bad NRZI level or a missed stuff bit flips every following payload cycle until the end-of-packet. Because of that, each packet's line trace is compared clock by clock against a stream built from the bytes. A broken hand-off between the waiting byte and the shifter shows as tx_ready rising during the header, or as an early SE0 within one bit time. A mode latched at the wrong moment swaps the whole low-speed timing for full-speed timing from the first payload bit.

// File: rtl/ls_pre_tx.sv
module ls_pre_tx #(
  parameter int FS_CLKS = 4,
  parameter int LS_RATIO = 8,
  parameter int GAP_BITS = 4,
  parameter int HOLD_BITS = 1,
  parameter logic [7:0] PRE_PID = 8'h3C,
  parameter logic [7:0] SYNC_B = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] xcvr_sel,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  input  logic       tx_last,
  output logic       tx_ready,
  output logic [1:0] line_out,
  output logic       line_oe,
  output logic       fs_edge
);
  localparam int LS_CLKS = FS_CLKS * LS_RATIO;
  localparam int TW = $clog2(2 * LS_CLKS);
  localparam int REL_CLKS = (GAP_BITS - HOLD_BITS) * FS_CLKS;
  localparam int HOLD_CLKS = HOLD_BITS * FS_CLKS;
  localparam logic [15:0] HDR_W = {PRE_PID, SYNC_B};
  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_GJ, S_GR, S_PAY, S_SE0, S_EJ} st_t;

  st_t st;
  logic [TW-1:0] tick, per;
  logic [14:0] hsr;
  logic [3:0] hcnt;
  logic [7:0] sh, nxt;
  logic [2:0] left, ones;
  logic sh_last, nxt_last, nxt_full, got_last, pre_m, lvl;
  logic fire, stuff, pend, pbit;

  assign tx_ready = (st == S_IDLE) ||
                    (st != S_SE0 && st != S_EJ && !nxt_full && !got_last);
  assign fire = tx_valid & tx_ready;
  assign per = pre_m ? TW'(LS_CLKS) : TW'(FS_CLKS);
  assign stuff = (ones == 3'd6);
  assign pend = !stuff && left == 3'd0 && (sh_last || !nxt_full);
  assign pbit = stuff ? 1'b0 : (left != 3'd0 ? sh[0] : nxt[0]);

  assign line_out = (st == S_SE0) ? LSE0 : (lvl ? LJ : LK);
  assign line_oe = (st != S_IDLE) && (st != S_GR);
  assign fs_edge = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tick <= '0;
      hsr <= '0;
      hcnt <= '0;
      sh <= '0;
      nxt <= '0;
      left <= '0;
      ones <= '0;
      sh_last <= 1'b0;
      nxt_last <= 1'b0;
      nxt_full <= 1'b0;
      got_last <= 1'b0;
      pre_m <= 1'b0;
      lvl <= 1'b1;
    end else begin
      if (fire) begin
        nxt <= tx_data;
        nxt_last <= tx_last;
        nxt_full <= 1'b1;
        if (tx_last) got_last <= 1'b1;
      end
      case (st)
        S_IDLE: if (fire) begin
          pre_m <= (xcvr_sel == 2'b11);
          tick <= TW'(FS_CLKS - 1);
          if (xcvr_sel == 2'b11) begin
            st <= S_HDR;
            hsr <= HDR_W[15:1];
            hcnt <= 4'd15;
            lvl <= HDR_W[0] ? 1'b1 : 1'b0;
          end else begin
            st <= S_PAY;
            sh <= SYNC_B >> 1;
            left <= 3'd7;
            sh_last <= 1'b0;
            ones <= SYNC_B[0] ? 3'd1 : 3'd0;
            lvl <= SYNC_B[0];
          end
        end
        S_HDR: if (tick == '0) begin
          tick <= TW'(FS_CLKS - 1);
          if (hcnt == 4'd0) begin
            st <= S_GJ;
            lvl <= 1'b1;
            tick <= TW'(HOLD_CLKS - 1);
          end else begin
            lvl <= hsr[0] ? lvl : ~lvl;
            hsr <= hsr >> 1;
            hcnt <= hcnt - 4'd1;
          end
        end else tick <= tick - TW'(1);
        S_GJ: if (tick == '0) begin
          st <= S_GR;
          tick <= TW'(REL_CLKS - 1);
        end else tick <= tick - TW'(1);
        S_GR: if (tick == '0) begin
          st <= S_PAY;
          sh <= SYNC_B >> 1;
          left <= 3'd7;
          sh_last <= 1'b0;
          ones <= SYNC_B[0] ? 3'd1 : 3'd0;
          lvl <= SYNC_B[0];
          tick <= per - TW'(1);
        end else tick <= tick - TW'(1);
        S_PAY: if (tick == '0) begin
          if (pend) begin
            st <= S_SE0;
            tick <= (per << 1) - TW'(1);
          end else begin
            lvl <= pbit ? lvl : ~lvl;
            ones <= pbit ? ones + 3'd1 : 3'd0;
            tick <= per - TW'(1);
            if (!stuff) begin
              if (left != 3'd0) begin
                sh <= sh >> 1;
                left <= left - 3'd1;
              end else begin
                sh <= nxt >> 1;
                left <= 3'd7;
                sh_last <= nxt_last;
                nxt_full <= 1'b0;
              end
            end
          end
        end else tick <= tick - TW'(1);
        S_SE0: if (tick == '0) begin
          st <= S_EJ;
          lvl <= 1'b1;
          tick <= per - TW'(1);
        end else tick <= tick - TW'(1);
        S_EJ: if (tick == '0) begin
          st <= S_IDLE;
          got_last <= 1'b0;
          nxt_full <= 1'b0;
        end else tick <= tick - TW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_HDR_THEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && tick == '0 && hcnt == 4'd0) |=> (line_out == LJ && line_oe)); // R4
  AST_WAITING_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_full |-> !tx_ready); // R9
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(pre_m)); // R10
  AST_STUFF_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd6); // R7
  AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAY && tick != '0) |=> $stable(line_out)); // R6
endmodule

// File: tb/ls_pre_tx_tb.sv
module ls_pre_tx_tb;
  localparam int CLK_P = 10;
  localparam int MAXL = 4096;
  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] xcvr_sel = 2'b11;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0;
  logic tx_last = 1'b0;
  logic tx_ready, line_oe, fs_edge;
  logic [1:0] line_out;

  always #(CLK_P / 2) clk = ~clk;

  ls_pre_tx u_dut (
    .clk(clk), .rst_n(rst_n), .xcvr_sel(xcvr_sel), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .line_out(line_out), .line_oe(line_oe), .fs_edge(fs_edge)
  );

  int total = 0;
  int bad = 0;
  logic [1:0] e_ln[MAXL];
  logic e_oe[MAXL];
  logic [3:0] e_ph[MAXL];
  int e_len;
  logic [7:0] pb[8];
  int pn;

  function automatic string tag(input logic [3:0] p);
    case (p)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] ln, input logic oe, input logic [3:0] ph, input int n);
    for (int i = 0; i < n; i++) begin
      e_ln[e_len] = ln;
      e_oe[e_len] = oe;
      e_ph[e_len] = ph;
      e_len++;
    end
  endtask

  task automatic build(input bit pre);
    logic lv;
    logic [15:0] hw;
    logic [7:0] by;
    int per, ones;
    e_len = 0;
    lv = 1'b1;
    hw = {8'h3C, 8'h80};
    if (pre) begin
      for (int i = 0; i < 16; i++) begin
        if (!hw[i]) lv = ~lv;
        push(lv ? LJ : LK, 1'b1, 4'd3, 4);
      end
      push(LJ, 1'b1, 4'd4, 4);
      push(LJ, 1'b0, 4'd5, 12);
      lv = 1'b1;
    end
    per = pre ? 32 : 4;
    ones = 0;
    for (int j = 0; j <= pn; j++) begin
      by = (j == 0) ? 8'h80 : pb[j-1];
      for (int k = 0; k < 8; k++) begin
        if (!by[k]) lv = ~lv;
        ones = by[k] ? ones + 1 : 0;
        push(lv ? LJ : LK, 1'b1, pre ? 4'd6 : 4'd2, per);
        if (ones == 6) begin
          lv = ~lv;
          ones = 0;
          push(lv ? LJ : LK, 1'b1, 4'd7, per);
        end
      end
    end
    push(LSE0, 1'b1, 4'd8, 2 * per);
    push(LJ, 1'b1, 4'd8, per);
  endtask

  task automatic run_pkt(input bit flip_mid);
    bit pre;
    pre = (xcvr_sel == 2'b11);
    build(pre);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R9 idle ready", int'(tx_ready), 1);
    tx_data = pb[0];
    tx_last = (pn == 1);
    tx_valid = 1'b1;
    @(posedge clk);
    fork
      begin
        for (int j = 1; j < pn; j++) begin
          @(negedge clk);
          tx_data = pb[j];
          tx_last = (j == pn - 1);
          tx_valid = 1'b1;
          while (!tx_ready) @(negedge clk);
          @(posedge clk);
        end
        @(negedge clk);
        tx_valid = 1'b0;
        tx_last = 1'b0;
      end
      begin
        for (int i = 0; i < e_len + 3; i++) begin
          logic [2:0] ev;
          string rq;
          @(negedge clk);
          if (i < e_len) begin
            ev = {e_oe[i], e_ln[i]};
            rq = tag(e_ph[i]);
          end else begin
            ev = {1'b0, LJ};
            rq = "R8";
          end
          chk({line_oe, line_out} == ev, $sformatf("%s cyc=%0d", rq, i),
              int'({line_oe, line_out}), int'(ev));
          if (pre && pn > 1 && i == 8)
            chk(tx_ready == 1'b0, "R9 header busy", int'(tx_ready), 0);
          if (i == 20) chk(fs_edge == 1'b1, "R11", int'(fs_edge), 1);
          if (flip_mid && i == 40) xcvr_sel = ~xcvr_sel;
        end
      end
    join
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(line_out == LJ, "R1 line", int'(line_out), int'(LJ));
    chk(line_oe == 1'b0, "R1 oe", int'(line_oe), 0);
    chk(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    xcvr_sel = 2'b11; pn = 1; pb[0] = 8'hC3;
    run_pkt(1'b0);
    xcvr_sel = 2'b11; pn = 2; pb[0] = 8'hFF; pb[1] = 8'hFC;
    run_pkt(1'b0);
    xcvr_sel = 2'b01; pn = 2; pb[0] = 8'hA5; pb[1] = 8'h7E;
    run_pkt(1'b0);
    xcvr_sel = 2'b11; pn = 3; pb[0] = 8'h5A; pb[1] = 8'h3F; pb[2] = 8'h81;
    run_pkt(1'b1);
    chk(xcvr_sel == 2'b00, "R10 select flipped", int'(xcvr_sel), 0);
    pn = 1; pb[0] = 8'h96;
    run_pkt(1'b0);
    xcvr_sel = 2'b00; pn = 2; pb[0] = 8'h12; pb[1] = 8'h34;
    run_pkt(1'b1);

    for (int t = 0; t < 10; t++) begin
      xcvr_sel = 2'($urandom_range(0, 3));
      if (t % 2 == 0) xcvr_sel = 2'b11;
      pn = $urandom_range(1, 4);
      for (int j = 0; j < 4; j++) pb[j] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      run_pkt(1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule